// File: doc/BRIEF.md
# Legacy Memory Window Route Decoder

This block sits in a host bridge and decides where each processor access to the legacy region from 640 KB up to 1 MB goes. The region is cut into fourteen segments of unequal size, and each segment has a two-bit attribute. The attributes are packed two to a byte in a small bank of configuration registers. A 32-bit system-management RAM control register defines an overlay. When the overlay is active and its range is legal, it maps its range to DRAM for both reads and writes, whatever the segment attributes say.

Software writes configuration bytes through a plain byte port. The address, the direction and the system-management mode input arrive together with each access. One cycle later the block returns one of four route codes:
- main DRAM;
- dropped write (a ROM-like segment);
- forwarded to the legacy expansion bus;
- outside the window.

The block has no state machine. Its only state is the configuration bank and the registered route output.

Top module: `lwin_route_dec`

## Requirements
- R1: The window 0xA0000–0xFFFFF is split into 14 segments:
  - segment 0 covers 0xA0000–0xBFFFF;
  - segments 1 to 12 are 16 KB each, starting at 0xC0000;
  - segment 13 covers 0xF0000–0xFFFFF.
- R2: The attribute of segment i sits in the configuration byte at offset 0x61 + (i >> 1). An even segment uses bits [1:0] and an odd segment uses bits [5:4]. Bits [7:6] and [3:2] of these bytes have no effect on routing.
- R3: Attribute 3 routes both reads and writes to DRAM (route code 0).
- R4: Attribute 2 routes reads to DRAM (code 0) and drops writes (code 1).
- R5: Attribute 0 or 1 forwards the access to the expansion bus (code 2).
- R6: Any address below 0xA0000 or at 0x100000 and above, including addresses with high bits set, gives route code 3.
- R7: The overlay control register is 32 bits, little-endian, at offsets 0x6C–0x6F, and resets to 0x0000000A.
  - Base = bits [15:0] << 16.
  - Size = (bits [23:20] + 1) × 64 KB.
- R8: The overlay is active when bit 31 is set and the mode input is high, or when bit 26 is set. Inside an active overlay range [base, base+size), every access routes to DRAM (code 0) and the segment attribute is ignored.
- R9: An overlay whose base is below 0xA0000, or whose base + size exceeds 0x100000, is ignored. A range ending exactly at 0x100000 is honoured.
- R10: `rt_valid` and `rt_route` are registered one cycle after `acc_valid`. An access presented in the same cycle as a configuration write sees the old configuration. An access in the next cycle sees the new one. The mode input is sampled together with the access.
- R11: After reset:
  - all attribute bytes are zero, so the whole window goes to the expansion bus;
  - `rt_valid` is low;
  - writes to offsets other than 0x61–0x67 and 0x6C–0x6F have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration byte data |
| smm_active | input | 1 | System-management mode active |
| acc_valid | input | 1 | Access present |
| acc_addr | input | ADDR_W | Access byte address |
| acc_write | input | 1 | 1 = write, 0 = read |
| rt_valid | output | 1 | Route result valid |
| rt_route | output | 2 | 0 DRAM, 1 dropped write, 2 expansion bus, 3 outside |

## Verification
Two functions can fall in the same cycle: a configuration write that changes a segment attribute, and an access that targets that segment. The bench provokes this by raising the write strobe and the access in one cycle. The result must follow the old attribute, and an access in the next cycle must follow the new one. A second collision is between the overlay and a segment attribute over the same address. Here the bench toggles the mode input between back-to-back writes to a ROM-like segment. The result must switch between "dropped" and "DRAM" on exactly those accesses.

// File: rtl/lwin_pkg.sv
package lwin_pkg;
    typedef enum logic [1:0] {
        RT_DRAM    = 2'd0,
        RT_DROP    = 2'd1,
        RT_XBUS    = 2'd2,
        RT_OUTSIDE = 2'd3
    } route_e;

    localparam int unsigned NUM_SEG    = 14;
    localparam int unsigned ATTR_BYTES = (NUM_SEG + 1) / 2;
    localparam int unsigned CTRL_BYTES = 4;
endpackage

// File: rtl/lwin_cfg_regs.sv
module lwin_cfg_regs
    import lwin_pkg::*;
#(
    parameter logic [7:0]  ATTR_OFS  = 8'h61,
    parameter logic [7:0]  CTRL_OFS  = 8'h6C,
    parameter logic [31:0] CTRL_RST  = 32'h0000_000A
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [7:0]                cfg_addr,
    input  logic [7:0]                cfg_wdata,
    output logic [ATTR_BYTES*8-1:0]   attr_flat,
    output logic [CTRL_BYTES*8-1:0]   ctrl_word
);
    logic [7:0] attr_r [ATTR_BYTES];
    logic [7:0] ctrl_r [CTRL_BYTES];

    for (genvar g = 0; g < ATTR_BYTES; g++) begin : g_attr
        localparam logic [7:0] OFS_G = 8'(ATTR_OFS + g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                attr_r[g] <= 8'h00;
            else if (cfg_we && cfg_addr == OFS_G)
                attr_r[g] <= cfg_wdata;
        end
        assign attr_flat[g*8 +: 8] = attr_r[g];
    end

    for (genvar b = 0; b < CTRL_BYTES; b++) begin : g_ctrl
        localparam logic [7:0] OFS_B = 8'(CTRL_OFS + b);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctrl_r[b] <= CTRL_RST[b*8 +: 8];
            else if (cfg_we && cfg_addr == OFS_B)
                ctrl_r[b] <= cfg_wdata;
        end
        assign ctrl_word[b*8 +: 8] = ctrl_r[b];
    end
endmodule

// File: rtl/lwin_seg_lookup.sv
module lwin_seg_lookup
    import lwin_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic [ATTR_BYTES*8-1:0]  attr_flat,
    output logic                     in_win,
    output logic [1:0]               seg_attr
);
    localparam logic [ADDR_W-1:0] WIN_LO   = ADDR_W'(32'h000A_0000);
    localparam logic [ADDR_W-1:0] WIN_HI   = ADDR_W'(32'h0010_0000);
    localparam logic [19:0]       FINE_LO  = 20'hC0000;
    localparam logic [19:0]       FINE_HI  = 20'hF0000;
    localparam int unsigned       FINE_SH  = 14;
    localparam logic [3:0]        LAST_SEG = 4'(NUM_SEG - 1);

    logic [3:0] seg_idx;
    logic [7:0] attr_byte;

    assign in_win = (addr >= WIN_LO) && (addr < WIN_HI);

    always_comb begin
        if (addr[19:0] < FINE_LO)
            seg_idx = 4'd0;
        else if (addr[19:0] >= FINE_HI)
            seg_idx = LAST_SEG;
        else
            seg_idx = 4'd1 + addr[FINE_SH+3:FINE_SH];
    end

    always_comb begin
        attr_byte = attr_flat[seg_idx[3:1]*8 +: 8];
        seg_attr  = seg_idx[0] ? attr_byte[5:4] : attr_byte[1:0];
    end
endmodule

// File: rtl/lwin_smram_ovl.sv
module lwin_smram_ovl #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [31:0]        ctrl_word,
    input  logic               smm_active,
    input  logic [ADDR_W-1:0]  addr,
    output logic               ovl_hit
);
    localparam int unsigned CW = (ADDR_W > 33) ? ADDR_W : 33;
    localparam logic [CW-1:0] LEGAL_LO = CW'(32'h000A_0000);
    localparam logic [CW-1:0] LEGAL_HI = CW'(32'h0010_0000);

    logic [CW-1:0] base_x, size_x, end_x, addr_x;
    logic          ovl_on, ovl_legal;

    always_comb begin
        base_x    = CW'({ctrl_word[15:0], 16'h0000});
        size_x    = CW'({1'b0, ctrl_word[23:20]} + 5'd1) << 16;
        end_x     = base_x + size_x;
        addr_x    = CW'(addr);
        ovl_on    = (ctrl_word[31] && smm_active) || ctrl_word[26];
        ovl_legal = (base_x >= LEGAL_LO) && (end_x <= LEGAL_HI);
        ovl_hit   = ovl_on && ovl_legal && (addr_x >= base_x) && (addr_x < end_x);
    end
endmodule

// File: rtl/lwin_route_dec.sv
module lwin_route_dec
    import lwin_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              smm_active,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    output logic              rt_valid,
    output logic [1:0]        rt_route
);
    logic [ATTR_BYTES*8-1:0] attr_flat;
    logic [31:0]             ctrl_word;
    logic                    win_hit;
    logic [1:0]              seg_attr;
    logic                    ovl_hit;
    route_e                  route_d;

    lwin_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .attr_flat (attr_flat),
        .ctrl_word (ctrl_word)
    );

    lwin_seg_lookup #(.ADDR_W(ADDR_W)) u_seg (
        .addr      (acc_addr),
        .attr_flat (attr_flat),
        .in_win    (win_hit),
        .seg_attr  (seg_attr)
    );

    lwin_smram_ovl #(.ADDR_W(ADDR_W)) u_ovl (
        .ctrl_word  (ctrl_word),
        .smm_active (smm_active),
        .addr       (acc_addr),
        .ovl_hit    (ovl_hit)
    );

    always_comb begin
        if (!win_hit)
            route_d = RT_OUTSIDE;
        else if (ovl_hit)
            route_d = RT_DRAM;
        else begin
            unique case (seg_attr)
                2'd3:    route_d = RT_DRAM;
                2'd2:    route_d = acc_write ? RT_DROP : RT_DRAM;
                default: route_d = RT_XBUS;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rt_valid <= 1'b0;
            rt_route <= RT_XBUS;
        end else begin
            rt_valid <= acc_valid;
            if (acc_valid)
                rt_route <= route_d;
        end
    end
endmodule

// File: rtl/lwin_route_chk.sv
module lwin_route_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              in_win,
    input logic [1:0]        seg_attr,
    input logic              ovl_hit,
    input logic              rt_valid,
    input logic [1:0]        rt_route
);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(32'h000A_0000);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(32'h0010_0000);

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rt_valid);
    a_r10_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rt_valid);
    a_r6_outside: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && (acc_addr < LO || acc_addr >= HI) |=> rt_route == 2'd3);
    a_r4_drop_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write |=> rt_route != 2'd1);
    a_r8_overlay_wins: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && in_win && ovl_hit |=> rt_route == 2'd0);
    a_r5_xbus_attr: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && in_win && !ovl_hit && !seg_attr[1] |=> rt_route == 2'd2);
    a_r3_dram_attr: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && in_win && seg_attr == 2'd3 |=> rt_route == 2'd0);
endmodule

bind lwin_route_dec lwin_route_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .in_win    (win_hit),
    .seg_attr  (seg_attr),
    .ovl_hit   (ovl_hit),
    .rt_valid  (rt_valid),
    .rt_route  (rt_route)
);

// File: tb/tb_lwin_route_dec.sv
module tb_lwin_route_dec;
    localparam int unsigned ADDR_W = 32;
    localparam int NVEC = 17;

    // {address, write, expected route}
    localparam logic [34:0] VEC [NVEC] = '{
        {32'h000A_0000, 1'b0, 2'd0},
        {32'h000B_FFFF, 1'b1, 2'd0},
        {32'h000C_0000, 1'b0, 2'd0},
        {32'h000C_3FFF, 1'b1, 2'd1},
        {32'h000C_4000, 1'b0, 2'd2},
        {32'h000C_8000, 1'b1, 2'd2},
        {32'h000C_C000, 1'b1, 2'd1},
        {32'h000C_FFFF, 1'b0, 2'd0},
        {32'h000D_0000, 1'b1, 2'd0},
        {32'h000D_4000, 1'b0, 2'd2},
        {32'h000E_C000, 1'b1, 2'd1},
        {32'h000E_FFFF, 1'b0, 2'd0},
        {32'h000F_0000, 1'b1, 2'd0},
        {32'h000F_FFFF, 1'b0, 2'd0},
        {32'h0009_FFFF, 1'b0, 2'd3},
        {32'h0010_0000, 1'b1, 2'd3},
        {32'h100A_0000, 1'b0, 2'd3}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [7:0]        cfg_addr = 8'h00;
    logic [7:0]        cfg_wdata = 8'h00;
    logic              smm_active = 1'b0;
    logic              acc_valid = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic              acc_write = 1'b0;
    logic              rt_valid;
    logic [1:0]        rt_route;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lwin_route_dec #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .smm_active(smm_active), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_write(acc_write), .rt_valid(rt_valid),
        .rt_route(rt_route)
    );

    task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input string req, input logic [31:0] a, input logic w,
                          input logic smm, input logic [1:0] exp);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = w; smm_active = smm;
        @(negedge clk);
        acc_valid = 1'b0;
        check({req, " valid"}, {1'b0, rt_valid}, 2'd1);
        check(req, rt_route, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 rt_valid after reset", {1'b0, rt_valid}, 2'd0);
        rst_n = 1'b1;
        access("R11 reset attr xbus", 32'h000C_0000, 1'b1, 1'b0, 2'd2);
        access("R11 reset attr xbus top", 32'h000F_FFFF, 1'b0, 1'b1, 2'd2);
        // R11: writes to other offsets have no effect
        cfg_wr(8'h60, 8'hFF);
        cfg_wr(8'h68, 8'hFF);
        access("R11 stray offset ignored", 32'h000A_0000, 1'b0, 1'b0, 2'd2);
        access("R11 stray offset ignored hi", 32'h000F_0000, 1'b1, 1'b0, 2'd2);
        // R7: reset control value 0x0A has bits 31 and 26 clear
        access("R7 reset ctrl no overlay", 32'h000A_0000, 1'b1, 1'b1, 2'd2);

        // R2: pack attributes, with stray bits set in 0x63
        cfg_wr(8'h61, 8'h23);
        cfg_wr(8'h62, 8'h10);
        cfg_wr(8'h63, 8'hFE);
        cfg_wr(8'h67, 8'h32);
        // R1 R2 R3 R4 R5 R6: vector table walk
        for (int i = 0; i < NVEC; i++) begin
            access("R1/R2 table R3 R4 R5 R6", VEC[i][34:3], VEC[i][2], 1'b0, VEC[i][1:0]);
        end

        // R8: overlay base 0xC0000, size 128K, bit31 mode gated
        cfg_wr(8'h6C, 8'h0C);
        cfg_wr(8'h6D, 8'h00);
        cfg_wr(8'h6E, 8'h10);
        cfg_wr(8'h6F, 8'h80);
        access("R8 mode low attr rules", 32'h000C_3FFF, 1'b1, 1'b0, 2'd1);
        access("R8 mode high overlay", 32'h000C_3FFF, 1'b1, 1'b1, 2'd0);
        access("R8 mode low again", 32'h000C_3FFF, 1'b1, 1'b0, 2'd1);
        access("R8 overlay over xbus", 32'h000D_4000, 1'b0, 1'b1, 2'd0);
        access("R8 overlay last byte", 32'h000D_FFFF, 1'b1, 1'b1, 2'd0);
        access("R8 overlay end exclusive", 32'h000E_0000, 1'b0, 1'b1, 2'd2);
        // R8: bit26 forces overlay without mode
        cfg_wr(8'h6F, 8'h04);
        access("R8 bit26 forced", 32'h000C_3FFF, 1'b1, 1'b0, 2'd0);
        // R9: base 0xE0000 size 192K runs past 1 MB -> ignored
        cfg_wr(8'h6C, 8'h0E);
        cfg_wr(8'h6E, 8'h20);
        access("R9 overflow ignored", 32'h000E_0000, 1'b0, 1'b0, 2'd2);
        // R9: base 0xE0000 size 128K ends exactly at 1 MB -> honoured
        cfg_wr(8'h6E, 8'h10);
        access("R9 exact end honoured", 32'h000E_0000, 1'b0, 1'b0, 2'd0);
        // R9: base 0x90000 below window -> ignored
        cfg_wr(8'h6C, 8'h09);
        cfg_wr(8'h6E, 8'hF0);
        access("R9 low base ignored", 32'h000D_4000, 1'b0, 1'b0, 2'd2);
        cfg_wr(8'h6F, 8'h00);

        // R10: config write and access in the same cycle use the old attribute
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'h64; cfg_wdata = 8'h03;
        acc_valid = 1'b1; acc_addr = 32'h000D_4000; acc_write = 1'b0; smm_active = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R10 same cycle old attr", rt_route, 2'd2);
        acc_addr = 32'h000D_4000;
        @(negedge clk);
        acc_valid = 1'b0;
        check("R10 next cycle new attr", rt_route, 2'd0);
        @(negedge clk);
        check("R10 idle drops valid", {1'b0, rt_valid}, 2'd0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule